// File: doc/BRIEF.md
# PLL Dynamic Phase-Step Sequencer

This block takes a request from user logic and turns it into a series of single phase steps on a PLL's dynamic phase-shift port. A request carries a counter select code, a direction and a step count. The controller drives a step strobe, a direction line and a select bus to the PLL, all timed by the scan clock. For each step it waits for the PLL's done line to go low and then return high before it issues the next one. Each step moves the selected output clock by one eighth of a VCO period. Any number of steps may be chained.

The step strobe comes from a rising-edge register, so it never changes near the falling edges on which the PLL samples it. It is held high for a programmable number of whole cycles. Direction and select are latched when the request is accepted and stay fixed for the whole sequence, so they are stable at the PLL's capture edge. The done line is passed through a two-stage synchronizer. A step counts as complete only after done has been seen low and then high again.

The low time of done depends on the VCO and scan-clock frequencies, so the controller waits for the done edges rather than counting a fixed number of cycles. A timeout per step aborts a sequence that stalls and raises an error flag. A request with a step count of zero finishes at once.

Top module: `phase_step_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, busy, finished, error and the step strobe are all low. The controller is idle.
- R2: A start in idle with a non-zero count raises busy on the next cycle. The select and direction seen at that start are latched (direction 1 = shift up, 0 = shift down). The PLL select and direction outputs keep those values for as long as busy is high.
- R3: The step strobe is driven from a rising-edge register. Each step holds it high for HOLD_CYC consecutive cycles (default 2).
- R4: After the first step, a step is issued only once the synchronized done has been seen low and has then returned high. A step never begins while done is low.
- R5: A sequence with count N issues exactly N steps. It then gives a finished pulse of exactly one cycle, and busy is low in that same cycle.
- R6: A start with a count of zero gives a finished pulse on the next cycle. It issues no step and busy stays low.
- R7: A start received while busy is ignored. The running sequence keeps its select, direction and remaining count.
- R8: If done fails to complete its low-then-high cycle within TIMEOUT scan cycles (default 1024) of a step being issued, the sequence is aborted. This covers done never falling and done never rising. On abort, error goes high, busy and the step strobe go low, and no finished pulse is given.
- R9: The error flag stays high until the next accepted start, which clears it.
- R10: Sequences complete correctly whether done stays low for a single cycle or for many cycles.
- R11: A start present in the cycle of a finished pulse is accepted, and a new sequence begins with the new parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock; all logic on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, sampled in idle |
| sel_i | input | SEL_W (4) | Counter select code for the request |
| dir_i | input | 1 | Shift direction, 1 = up |
| count_i | input | CNT_W (16) | Number of phase steps |
| busy_o | output | 1 | Sequence in progress |
| finished_o | output | 1 | One-cycle pulse on successful completion |
| error_o | output | 1 | Sticky timeout flag, cleared by next accepted start |
| pll_step_o | output | 1 | Phase-step strobe to the PLL |
| pll_dir_o | output | 1 | Direction to the PLL |
| pll_sel_o | output | SEL_W (4) | Counter select to the PLL |
| pll_done_i | input | 1 | Done from the PLL, asynchronous to this logic |

## Verification
The end of one sequence and the acceptance of the next request can fall in the same cycle. The finished pulse leaves the sequencer idle in exactly the cycle in which a waiting start is sampled. The bench provokes this by holding start high, with new select and count values, from the middle of a running sequence. That start must be ignored while busy, and must then be taken on the edge that closes the finished cycle. The bench judges the result by the step totals it counts per select code: both sequences must show their full counts. It also checks that busy is high one cycle after the finished pulse.

// File: rtl/phstep_pkg.sv
package phstep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_WAIT = 2'd2
    } phstep_state_e;
endpackage

// File: rtl/phstep_sync.sv
module phstep_sync #(
    parameter int    STAGES  = 2,
    parameter logic  RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] ff_d, ff_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb ff_d = async_i;
        end else begin : g_many
            always_comb ff_d = {ff_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) ff_q <= {STAGES{RST_VAL}};
        else       ff_q <= ff_d;
    end

    assign sync_o = ff_q[STAGES-1];
endmodule

// File: rtl/phstep_timer.sv
module phstep_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic en_i,
    output logic expired_o
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired_o = en_i && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                     cnt_d = '0;
        else if (en_i && !expired_o)   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end
endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
    import phstep_pkg::*;
#(
    parameter int SEL_W    = 4,
    parameter int CNT_W    = 16,
    parameter int HOLD_CYC = 2,
    parameter int TIMEOUT  = 1024,
    parameter int SYNC_STG = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             dir_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             busy_o,
    output logic             finished_o,
    output logic             error_o,
    output logic             pll_step_o,
    output logic             pll_dir_o,
    output logic [SEL_W-1:0] pll_sel_o,
    input  logic             pll_done_i
);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        phstep_state_e    st;
        logic [CNT_W-1:0] left;
        logic [HOLD_W-1:0] hold;
        logic             low_seen;
        logic [SEL_W-1:0] sel;
        logic             dir;
        logic             step;
        logic             busy;
        logic             fin;
        logic             err;
    } regs_t;

    regs_t d, q;
    logic  done_s;
    logic  expired;
    logic  issue;

    phstep_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .async_i(pll_done_i),
        .sync_o (done_s)
    );

    phstep_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .clr_i    (issue),
        .en_i     (q.st != ST_IDLE),
        .expired_o(expired)
    );

    always_comb begin
        d       = q;
        d.fin   = 1'b0;
        issue   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.err = 1'b0;
                    d.sel = sel_i;
                    d.dir = dir_i;
                    if (count_i == '0) begin
                        d.fin = 1'b1;
                    end else begin
                        d.st       = ST_STEP;
                        d.left     = count_i;
                        d.step     = 1'b1;
                        d.busy     = 1'b1;
                        d.hold     = '0;
                        d.low_seen = 1'b0;
                        issue      = 1'b1;
                    end
                end
            end
            ST_STEP: begin
                if (!done_s) d.low_seen = 1'b1;
                if (q.hold == HOLD_W'(HOLD_CYC - 1)) begin
                    d.step = 1'b0;
                    d.st   = ST_WAIT;
                end else begin
                    d.hold = q.hold + 1'b1;
                end
                if (expired) begin
                    d.st   = ST_IDLE;
                    d.step = 1'b0;
                    d.busy = 1'b0;
                    d.err  = 1'b1;
                end
            end
            ST_WAIT: begin
                if (!done_s) d.low_seen = 1'b1;
                if (q.low_seen && done_s) begin
                    if (q.left == CNT_W'(1)) begin
                        d.st   = ST_IDLE;
                        d.busy = 1'b0;
                        d.fin  = 1'b1;
                        d.left = '0;
                    end else begin
                        d.left     = q.left - 1'b1;
                        d.st       = ST_STEP;
                        d.step     = 1'b1;
                        d.hold     = '0;
                        d.low_seen = 1'b0;
                        issue      = 1'b1;
                    end
                end else if (expired) begin
                    d.st   = ST_IDLE;
                    d.step = 1'b0;
                    d.busy = 1'b0;
                    d.err  = 1'b1;
                end
            end
            default: begin
                d.st   = ST_IDLE;
                d.step = 1'b0;
                d.busy = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '0;
        else       q <= d;
    end

    assign busy_o     = q.busy;
    assign finished_o = q.fin;
    assign error_o    = q.err;
    assign pll_step_o = q.step;
    assign pll_dir_o  = q.dir;
    assign pll_sel_o  = q.sel;

    // R1: no strobe outside a sequence
    p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> !pll_step_o);

    // R2: select and direction frozen while busy
    p_select_stable_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && $past(busy_o)) |-> ($stable(pll_sel_o) && $stable(pll_dir_o)));

    // R3: strobe lasts more than one cycle
    p_step_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pll_step_o) |=> pll_step_o);

    // R4: a chained step needs done seen high
    p_step_after_done_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(pll_step_o) && $past(busy_o)) |-> $past(done_s));

    // R5: finished is a single pulse while idle
    p_fin_pulse_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        finished_o |=> !finished_o);
    p_fin_idle_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        finished_o |-> !busy_o);

    // R8: abort leaves the port quiet
    p_abort_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(error_o) |-> (!busy_o && !pll_step_o && !finished_o));
endmodule

// File: tb/phase_step_ctrl_bench.sv
`timescale 1ns/1ps
module phase_step_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] sel = '0;
    logic       dir = 1'b0;
    logic [15:0] count = '0;
    logic       busy, finished, error, pll_step, pll_dir;
    logic [3:0] pll_sel;
    logic       done = 1'b1;

    int checks = 0;
    int fails  = 0;

    // responder controls and observations
    int mode   = 0;   // 0 normal, 1 done never falls, 2 done never rises
    int lowlen = 1;
    int steps  = 0;
    int ups    = 0;
    int dns    = 0;
    int by_sel [16];
    int hl     = 0;
    int min_hl = 1000;
    int rise_bad = 0;
    int fin_cnt  = 0;
    logic prev_step = 1'b0;

    always #2 clk = ~clk;

    phase_step_ctrl u_phase_step_ctrl (
        .clk_i(clk), .rst_i(rst), .start_i(start), .sel_i(sel), .dir_i(dir),
        .count_i(count), .busy_o(busy), .finished_o(finished), .error_o(error),
        .pll_step_o(pll_step), .pll_dir_o(pll_dir), .pll_sel_o(pll_sel),
        .pll_done_i(done)
    );

    typedef struct packed {
        logic [3:0]  vsel;
        logic        vdir;
        logic [15:0] vcnt;
        logic [7:0]  vlow;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{vsel: 4'd0,  vdir: 1'b1, vcnt: 16'd1,  vlow: 8'd1},
        '{vsel: 4'd3,  vdir: 1'b0, vcnt: 16'd4,  vlow: 8'd2},
        '{vsel: 4'd7,  vdir: 1'b1, vcnt: 16'd6,  vlow: 8'd9},
        '{vsel: 4'd15, vdir: 1'b0, vcnt: 16'd3,  vlow: 8'd3},
        '{vsel: 4'd9,  vdir: 1'b1, vcnt: 16'd40, vlow: 8'd1}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_obs();
        steps = 0; ups = 0; dns = 0; fin_cnt = 0; min_hl = 1000; rise_bad = 0;
        for (int i = 0; i < 16; i++) by_sel[i] = 0;
    endtask

    task automatic kick(input logic [3:0] s, input logic d, input logic [15:0] c);
        @(negedge clk);
        sel = s; dir = d; count = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_fin(output int cyc);
        cyc = 0;
        while (!finished && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // behavioural PLL handshake responder
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && pll_step) begin
                @(posedge clk);
                @(posedge clk);
                steps++;
                by_sel[pll_sel]++;
                if (pll_dir) ups++; else dns++;
                if (mode != 1) begin
                    #1 done = 1'b0;
                    if (mode == 0) begin
                        repeat (lowlen) @(posedge clk);
                        #1 done = 1'b1;
                    end
                end
                while (pll_step) @(negedge clk);
            end
        end
    end

    // strobe width, strobe-vs-done and finished monitors
    always @(negedge clk) begin
        if (rst) hl = 0;
        else if (pll_step) hl++;
        else begin
            if (hl > 0 && hl < min_hl) min_hl = hl;
            hl = 0;
        end
        if (!rst && pll_step && !prev_step && !done) rise_bad++;
        prev_step = pll_step;
        if (!rst && finished) fin_cnt++;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        for (int i = 0; i < 16; i++) by_sel[i] = 0;
        repeat (3) @(negedge clk);
        // R1: during reset
        chk(!busy && !finished && !error && !pll_step, "R1", "outputs in reset",
            {busy, finished, error, pll_step}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !finished && !error && !pll_step, "R1", "outputs after reset",
            {busy, finished, error, pll_step}, 0);

        // vector table: R2 R3 R4 R5 R10
        for (int v = 0; v < 5; v++) begin
            clear_obs();
            lowlen = int'(VECS[v].vlow);
            kick(VECS[v].vsel, VECS[v].vdir, VECS[v].vcnt);
            chk(busy == 1'b1, "R2", "busy after start", busy, 1);
            chk(pll_sel == VECS[v].vsel && pll_dir == VECS[v].vdir, "R2", "latched select",
                pll_sel, VECS[v].vsel);
            wait_fin(cyc);
            chk(finished && !busy, "R5", "finished with busy low", {finished, busy}, 2);
            @(negedge clk);
            chk(!finished, "R5", "finished one cycle", finished, 0);
            repeat (3) @(negedge clk);
            chk(steps == int'(VECS[v].vcnt), "R5", "step total", steps, int'(VECS[v].vcnt));
            chk(by_sel[VECS[v].vsel] == int'(VECS[v].vcnt), "R10", "steps on select",
                by_sel[VECS[v].vsel], int'(VECS[v].vcnt));
            chk((VECS[v].vdir ? ups : dns) == int'(VECS[v].vcnt), "R2", "direction at capture",
                VECS[v].vdir ? ups : dns, int'(VECS[v].vcnt));
            chk(min_hl == 2, "R3", "strobe width", min_hl, 2);
            chk(rise_bad == 0, "R4", "strobe while done low", rise_bad, 0);
            chk(fin_cnt == 1, "R5", "finished pulses", fin_cnt, 1);
        end

        // R6: zero count
        clear_obs();
        kick(4'd5, 1'b1, 16'd0);
        chk(finished && !busy && !pll_step, "R6", "zero count finish",
            {finished, busy, pll_step}, 4);
        @(negedge clk);
        chk(!finished && !busy, "R6", "zero count pulse ends", {finished, busy}, 0);
        repeat (10) @(negedge clk);
        chk(steps == 0, "R6", "zero count steps", steps, 0);

        // R7: start while busy ignored
        clear_obs();
        lowlen = 3;
        kick(4'd5, 1'b0, 16'd3);
        repeat (6) @(negedge clk);
        sel = 4'd9; dir = 1'b1; count = 16'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(pll_sel == 4'd5 && pll_dir == 1'b0, "R7", "select kept", pll_sel, 5);
        wait_fin(cyc);
        repeat (5) @(negedge clk);
        chk(steps == 3 && by_sel[5] == 3, "R7", "steps of first request", steps, 3);
        chk(dns == 3, "R7", "direction kept", dns, 3);

        // R11: start held into finished cycle
        clear_obs();
        lowlen = 2;
        kick(4'd1, 1'b1, 16'd2);
        repeat (4) @(negedge clk);
        sel = 4'd2; dir = 1'b0; count = 16'd2; start = 1'b1;
        wait_fin(cyc);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && pll_sel == 4'd2, "R11", "accepted at finish", pll_sel, 2);
        wait_fin(cyc);
        repeat (5) @(negedge clk);
        chk(by_sel[1] == 2 && by_sel[2] == 2, "R11", "both sequences complete",
            by_sel[1] * 10 + by_sel[2], 22);

        // R8: done never falls
        clear_obs();
        mode = 1;
        kick(4'd6, 1'b1, 16'd3);
        cyc = 0;
        while (!error && cyc < 1500) begin @(negedge clk); cyc++; end
        chk(error && !busy && !pll_step, "R8", "abort on no fall", {error, busy, pll_step}, 4);
        chk(fin_cnt == 0, "R8", "no finished on abort", fin_cnt, 0);
        chk(cyc > 1000, "R8", "timeout length", cyc, 1020);
        repeat (3) @(negedge clk);
        chk(error == 1'b1, "R9", "error sticky", error, 1);

        // R9: next start clears error
        mode = 0; lowlen = 1;
        kick(4'd6, 1'b1, 16'd1);
        chk(!error, "R9", "error cleared by start", error, 0);
        wait_fin(cyc);
        chk(finished == 1'b1, "R9", "run after error", finished, 1);

        // R8: done never rises
        clear_obs();
        mode = 2;
        kick(4'd8, 1'b0, 16'd4);
        cyc = 0;
        while (!error && cyc < 1500) begin @(negedge clk); cyc++; end
        chk(error && !busy && !pll_step, "R8", "abort on no rise", {error, busy, pll_step}, 4);
        chk(steps == 1, "R8", "steps before abort", steps, 1);
        done = 1'b1; mode = 0;
        repeat (5) @(negedge clk);

        // R1: reset in the middle of a run
        lowlen = 4;
        kick(4'd3, 1'b1, 16'd10);
        repeat (12) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !pll_step && !finished && !error, "R1", "reset mid run",
            {busy, pll_step, finished, error}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !pll_step, "R1", "idle after mid reset", {busy, pll_step}, 0);
        repeat (10) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule